// File: doc/BRIEF.md
# Scaled Compare Timer

This block is a memory-mapped timer with four compare channels. A 31-bit counter steps by one per clock while either of two run bits is set: one keeps it running, the other lets it run until a stop event. The comparators do not look at the whole counter. A programmable right shift takes a 16-bit window out of the counter, and each channel compares that window against its own 16-bit threshold. When the window has reached a channel's threshold, the channel raises a pending flag, and its interrupt line follows that flag.

Software talks to the block through a plain 32-bit register port. Writes are strobed and reads are combinational. The port reaches a configuration word, the raw counter, the scaled window and the four thresholds. Writing the scaled window loads the counter with that value shifted back up by the same amount. Two events stop the run-until-stop mode. One is the counter wrapping past its top value. The other is a channel-0 match when the zero-on-match option is enabled, and that match also sends the counter back to zero.

Top module: `scaled_cmp_timer`

## Requirements
- R1: While reset is held, every register reads zero and all interrupt lines are low.
- R2: The counter steps by one on each clock only while configuration bit 12 (run continuously) or bit 13 (run until stop) is set. With both bits clear it keeps its value.
- R3: The counter at offset 0x08 is 31 bits wide and always reads with bit 31 at zero. From 0x7FFFFFFF it rolls over to 0.
- R4: Offset 0x10 reads the counter shifted right by configuration bits [3:0] and masked to 16 bits.
- R5: The threshold registers sit at offsets 0x20, 0x24, 0x28 and 0x2C for channels 0 to 3. Each keeps only the low 16 bits of a write and reads zero above them.
- R6: Whenever the scaled window is greater than or equal to the threshold of channel i, configuration bit 28+i and irq[i] are high from the next clock on, whether or not the counter is running.
- R7: If configuration bit 9 is set and channel 0 matches, the counter is zero on the next clock and bit 13 is cleared.
- R8: When the counter rolls over while running, bit 13 is cleared on that same clock. Bit 12 is left as it was.
- R9: A write to 0x08 loads the counter with wdata[30:0]. A write to 0x10 loads it with (wdata[15:0] shifted left by the current scale) masked to 31 bits.
- R10: A write to offset 0x00 stores the full word on the next clock, pending bits included. A pending bit written as zero takes irq low on that clock.
- R11: Any offset not listed above reads zero, and a write to it changes nothing.
- R12: In a clock where a register write coincides with a hardware update (counter step, wrap, zero-on-match, pending set, stop-bit clear), the written value wins for that register.
- R13: The bits in the configuration word that carry no function here are stored and read back, and they have no effect on counting or matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, captured on the rising edge |
| reg_addr | input | 8 | Byte offset in the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 4 | Per-channel interrupt, equal to the pending bits |

## Verification
Reads are combinational, so a register value reflects the last rising edge within the same cycle. A write shows on readback after the edge that captures it. A match seen at one edge shows in the pending bits and on irq at the following edge. A counter step, a wrap and a zero-on-match each take effect at the edge where they are evaluated. The bench drives its inputs shortly after each rising edge and compares the design against a behavioural model at the falling edge, which is the point where all of these delays have settled. Directed checks are placed so that every expected value comes from counting edges from the stimulus.

// File: rtl/scmp_pkg.sv
package scmp_pkg;

  localparam int unsigned REG_W = 32;

  // Register offsets; channel thresholds follow OFS_CMP0 at a 4-byte stride
  localparam logic [7:0] OFS_CFG  = 8'h00;
  localparam logic [7:0] OFS_CNT  = 8'h08;
  localparam logic [7:0] OFS_VIEW = 8'h10;
  localparam logic [7:0] OFS_CMP0 = 8'h20;

  // Configuration bit positions that carry behaviour
  localparam int unsigned CFG_ZCMP     = 9;
  localparam int unsigned CFG_RUN_ALW  = 12;
  localparam int unsigned CFG_RUN_ONCE = 13;
  localparam int unsigned CFG_PEND_LO  = 28;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_CNT,
    SEL_VIEW,
    SEL_CMP
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [7:0] ch;
  } reg_dec_t;

  function automatic logic [REG_W-1:0] low_mask(input int unsigned w);
    if (w >= REG_W) return '1;
    return (REG_W'(1) << w) - REG_W'(1);
  endfunction

  // Window of the counter that the comparators see
  function automatic logic [REG_W-1:0] scaled_view(input logic [REG_W-1:0] cnt,
                                                   input logic [4:0] shift,
                                                   input int unsigned vw);
    return (cnt >> shift) & low_mask(vw);
  endfunction

  // Counter value implied by writing the window
  function automatic logic [REG_W-1:0] scaled_load(input logic [REG_W-1:0] value,
                                                   input logic [4:0] shift,
                                                   input int unsigned vw,
                                                   input int unsigned cw);
    return ((value & low_mask(vw)) << shift) & low_mask(cw);
  endfunction

endpackage

// File: rtl/scmp_decode.sv
module scmp_decode
  import scmp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_CH   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_dec_t          dec
);

  always_comb begin
    dec.sel = SEL_NONE;
    dec.ch  = '0;
    if (addr == ADDR_W'(OFS_CFG)) begin
      dec.sel = SEL_CFG;
    end else if (addr == ADDR_W'(OFS_CNT)) begin
      dec.sel = SEL_CNT;
    end else if (addr == ADDR_W'(OFS_VIEW)) begin
      dec.sel = SEL_VIEW;
    end
    for (int i = 0; i < N_CH; i++) begin
      if (addr == ADDR_W'(32'(OFS_CMP0) + 32'(4 * i))) begin
        dec.sel = SEL_CMP;
        dec.ch  = 8'(i);
      end
    end
  end

endmodule

// File: rtl/scmp_counter.sv
module scmp_counter #(
  parameter int unsigned CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             zero_evt,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             carry_evt
);

  // Wrap happens on the step taken from the all-ones value
  assign carry_evt = run && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld_en) begin
      cnt_q <= ld_val;
    end else if (zero_evt) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/scmp_channel.sv
module scmp_channel #(
  parameter int unsigned CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMP_W-1:0] wr_val,
  input  logic [CMP_W-1:0] view,
  output logic [CMP_W-1:0] cmp_q,
  output logic             hit
);

  assign hit = (view >= cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (wr_en) begin
      cmp_q <= wr_val;
    end
  end

endmodule

// File: rtl/scmp_ctrl.sv
module scmp_ctrl
  import scmp_pkg::*;
#(
  parameter int unsigned N_CH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_val,
  input  logic [N_CH-1:0]  hit,
  input  logic             zero_evt,
  input  logic             carry_evt,
  output logic [REG_W-1:0] cfg_q
);

  logic [REG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    cfg_d[CFG_PEND_LO +: N_CH] = cfg_q[CFG_PEND_LO +: N_CH] | hit;
    if (zero_evt || carry_evt) begin
      cfg_d[CFG_RUN_ONCE] = 1'b0;
    end
    if (wr_en) begin
      cfg_d = wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/scaled_cmp_timer.sv
module scaled_cmp_timer #(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned CNT_W   = 31,
  parameter int unsigned CMP_W   = 16,
  parameter int unsigned SCALE_W = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [N_CH-1:0]   irq
);
  import scmp_pkg::*;

  reg_dec_t         dec;
  logic [REG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ld_val;
  logic [CMP_W-1:0] view;
  logic [CMP_W-1:0] cmp_q [N_CH];
  logic [N_CH-1:0]  hit;
  logic [N_CH-1:0]  cmp_wr;
  logic [SCALE_W-1:0] scale;
  logic             run;
  logic             run_once;
  logic             zero_evt;
  logic             carry_evt;
  logic             cfg_wr;
  logic             cnt_ld;

  scmp_decode #(.ADDR_W(ADDR_W), .N_CH(N_CH)) u_dec (
    .addr (reg_addr),
    .dec  (dec)
  );

  // Named events shared by the datapath and the checker
  assign scale    = cfg_q[SCALE_W-1:0];
  assign run_once = cfg_q[CFG_RUN_ONCE];
  assign run      = cfg_q[CFG_RUN_ALW] | run_once;
  assign view     = CMP_W'(scaled_view(REG_W'(cnt_q), 5'(scale), CMP_W));
  assign zero_evt = cfg_q[CFG_ZCMP] & hit[0];
  assign cfg_wr   = reg_wr && (dec.sel == SEL_CFG);
  assign cnt_ld   = reg_wr && ((dec.sel == SEL_CNT) || (dec.sel == SEL_VIEW));
  assign ld_val   = (dec.sel == SEL_CNT) ? reg_wdata[CNT_W-1:0]
                  : CNT_W'(scaled_load(reg_wdata, 5'(scale), CMP_W, CNT_W));

  scmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .zero_evt  (zero_evt),
    .ld_en     (cnt_ld),
    .ld_val    (ld_val),
    .cnt_q     (cnt_q),
    .carry_evt (carry_evt)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign cmp_wr[g] = reg_wr && (dec.sel == SEL_CMP) && (dec.ch == 8'(g));
    scmp_channel #(.CMP_W(CMP_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cmp_wr[g]),
      .wr_val (reg_wdata[CMP_W-1:0]),
      .view   (view),
      .cmp_q  (cmp_q[g]),
      .hit    (hit[g])
    );
  end

  scmp_ctrl #(.N_CH(N_CH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .wr_val    (reg_wdata),
    .hit       (hit),
    .zero_evt  (zero_evt),
    .carry_evt (carry_evt),
    .cfg_q     (cfg_q)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (dec.sel)
      SEL_CFG:  reg_rdata = cfg_q;
      SEL_CNT:  reg_rdata = REG_W'(cnt_q);
      SEL_VIEW: reg_rdata = REG_W'(view);
      SEL_CMP: begin
        for (int i = 0; i < N_CH; i++) begin
          if (dec.ch == 8'(i)) reg_rdata = REG_W'(cmp_q[i]);
        end
      end
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = cfg_q[CFG_PEND_LO +: N_CH];

endmodule

// File: rtl/scmp_checker.sv
module scmp_checker
  import scmp_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned CNT_W  = 31,
  parameter int unsigned CMP_W  = 16,
  parameter int unsigned ADDR_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   run,
  input logic                   run_once,
  input logic [CNT_W-1:0]       cnt_q,
  input logic [CNT_W-1:0]       ld_val,
  input logic [N_CH-1:0]        hit,
  input logic [N_CH-1:0]        pend,
  input logic                   cfg_wr,
  input logic                   cnt_ld,
  input logic                   zero_evt,
  input logic                   carry_evt,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic [REG_W-CMP_W-1:0] rd_hi
);

  logic in_cmp_range;
  assign in_cmp_range = (reg_addr >= ADDR_W'(OFS_CMP0))
                     && (reg_addr < ADDR_W'(32'(OFS_CMP0) + 32'(4 * N_CH)))
                     && (reg_addr[1:0] == 2'b00);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_ld && !zero_evt) |=> $stable(cnt_q)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_ld && !zero_evt) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2
  AST_CNT_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFS_CNT)) |-> !rd_hi[REG_W-CMP_W-1]); // R3
  AST_CMP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_cmp_range |-> (rd_hi == '0)); // R5
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ((pend & $past(hit)) == $past(hit))); // R6
  AST_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !cnt_ld) |=> (cnt_q == '0)); // R7
  AST_ZERO_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !cfg_wr) |=> !run_once); // R7
  AST_CARRY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_evt && !cfg_wr) |=> !run_once); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> (cnt_q == $past(ld_val))); // R12

endmodule

bind scaled_cmp_timer scmp_checker #(
  .N_CH(N_CH), .CNT_W(CNT_W), .CMP_W(CMP_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .run_once  (run_once),
  .cnt_q     (cnt_q),
  .ld_val    (ld_val),
  .hit       (hit),
  .pend      (irq),
  .cfg_wr    (cfg_wr),
  .cnt_ld    (cnt_ld),
  .zero_evt  (zero_evt),
  .carry_evt (carry_evt),
  .reg_addr  (reg_addr),
  .rd_hi     (reg_rdata[31:CMP_W])
);

// File: tb/sim_scaled_cmp_timer.sv
module sim_scaled_cmp_timer;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scaled_cmp_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_cfg = 32'h0;
  logic [30:0] m_cnt = 31'h0;
  logic [15:0] m_cmp [4];

  function automatic int m_view();
    longint t = longint'(m_cnt);
    for (int k = 0; k < int'(m_cfg[3:0]); k++) t = t / 2;
    return int'(t % 65536);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_cfg;
      8'h08: return {1'b0, m_cnt};
      8'h10: return 32'(m_view());
      8'h20, 8'h24, 8'h28, 8'h2C: return {16'h0, m_cmp[(a - 8'h20) >> 2]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R10 config";
      8'h08: return "R2 counter";
      8'h10: return "R4 scaled";
      8'h20, 8'h24, 8'h28, 8'h2C: return "R5 threshold";
      default: return "R11 unmapped";
    endcase
  endfunction

  always @(posedge clk) begin : ref_model
    logic [31:0] ncfg;
    logic [30:0] ncnt;
    longint      t;
    int          vw;
    if (!rst_n) begin
      m_cfg = 32'h0;
      m_cnt = 31'h0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 16'h0;
    end else begin
      vw   = m_view();
      ncfg = m_cfg;
      ncnt = m_cnt;
      for (int i = 0; i < 4; i++) if (vw >= int'(m_cmp[i])) ncfg[28+i] = 1'b1;
      if (m_cfg[12] || m_cfg[13]) begin
        if (m_cnt == 31'h7FFFFFFF) begin
          ncnt = 31'h0;
          ncfg[13] = 1'b0;
        end else begin
          ncnt = 31'(m_cnt + 1);
        end
      end
      if (m_cfg[9] && vw >= int'(m_cmp[0])) begin
        ncnt = 31'h0;
        ncfg[13] = 1'b0;
      end
      if (reg_wr) begin
        case (reg_addr)
          8'h00: ncfg = reg_wdata;
          8'h08: ncnt = reg_wdata[30:0];
          8'h10: begin
            t = longint'(reg_wdata[15:0]);
            for (int k = 0; k < int'(m_cfg[3:0]); k++) t = t * 2;
            ncnt = 31'(t & 64'h7FFFFFFF);
          end
          8'h20, 8'h24, 8'h28, 8'h2C: m_cmp[(reg_addr - 8'h20) >> 2] = reg_wdata[15:0];
          default: ;
        endcase
      end
      m_cfg = ncfg;
      m_cnt = ncnt;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 irq lines", {28'h0, irq}, {28'h0, m_cfg[31:28]});
      chk(tag_of(reg_addr), reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp,
                           input logic [31:0] mask, input string tag);
    @(posedge clk); #2;
    reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata & mask, exp & mask);
  endtask

  task automatic expect_irq(input logic [3:0] exp, input string tag);
    @(posedge clk); #2;
    @(negedge clk);
    chk(tag, {28'h0, irq}, {28'h0, exp});
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] c1;
    logic [31:0] c2;
    // R1: reset state
    repeat (2) @(posedge clk);
    expect_rd(8'h00, 32'h0, 32'hFFFFFFFF, "R1 config in reset");
    expect_rd(8'h08, 32'h0, 32'hFFFFFFFF, "R1 counter in reset");
    expect_rd(8'h2C, 32'h0, 32'hFFFFFFFF, "R1 threshold in reset");
    expect_irq(4'h0, "R1 irq in reset");
    @(posedge clk); #2;
    rst_n = 1'b1;

    // R6: thresholds at zero match at once, even while stopped
    expect_rd(8'h00, 32'hF0000000, 32'hFFFFFFFF, "R6 pending after reset");
    expect_irq(4'hF, "R6 irq after reset");

    // R5: threshold storage
    wr(8'h20, 32'h00012345);
    expect_rd(8'h20, 32'h00002345, 32'hFFFFFFFF, "R5 threshold 0 low half");
    wr(8'h24, 32'h00000010);
    wr(8'h28, 32'hFFFFFFFF);
    expect_rd(8'h28, 32'h0000FFFF, 32'hFFFFFFFF, "R5 threshold 2 upper zero");
    wr(8'h2C, 32'h00000100);

    // R10: clearing pending bits
    wr(8'h00, 32'h0);
    expect_irq(4'h0, "R10 irq cleared by config write");

    // R13: inert bits stored, no counting
    wr(8'h00, 32'h0F0F0500);
    expect_rd(8'h00, 32'h0F0F0500, 32'hFFFFFFFF, "R13 inert bits read back");
    repeat (4) @(posedge clk);
    expect_rd(8'h08, 32'h0, 32'hFFFFFFFF, "R13 counter still held");

    // R2: run then hold
    wr(8'h00, 32'h00001000);
    repeat (20) @(posedge clk);
    wr(8'h00, 32'h0);
    @(posedge clk); #2; reg_addr = 8'h08;
    @(negedge clk); c1 = reg_rdata;
    repeat (5) @(posedge clk);
    @(negedge clk); c2 = reg_rdata;
    chk("R2 counter holds when stopped", c2, c1);
    chk("R2 counter advanced while running", {31'h0, (c1 > 32'd15)}, 32'h1);

    // R9, R4: scaled load and view
    wr(8'h00, 32'h00000004);
    wr(8'h10, 32'h0000ABCD);
    expect_rd(8'h08, 32'h000ABCD0, 32'hFFFFFFFF, "R9 scaled write loads counter");
    expect_rd(8'h10, 32'h0000ABCD, 32'hFFFFFFFF, "R4 scaled view at shift 4");
    wr(8'h00, 32'h00000008);
    expect_rd(8'h10, 32'h00000ABC, 32'hFFFFFFFF, "R4 scaled view at shift 8");
    wr(8'h08, 32'hFFFFFFFF);
    expect_rd(8'h08, 32'h7FFFFFFF, 32'hFFFFFFFF, "R3 R9 raw write, bit 31 zero");

    // R8: wrap stops run-until-stop
    wr(8'h00, 32'h00002000);
    expect_rd(8'h08, 32'h0, 32'hFFFFFFFF, "R3 wrap to zero");
    expect_rd(8'h00, 32'h0, 32'h00003000, "R8 stop bit cleared by wrap");
    wr(8'h08, 32'h7FFFFFFE);
    wr(8'h00, 32'h00003000);
    expect_rd(8'h08, 32'h7FFFFFFF, 32'hFFFFFFFF, "R8 counter at top");
    expect_rd(8'h00, 32'h00001000, 32'h00003000, "R8 continuous bit kept on wrap");

    // R12: write beats the step
    wr(8'h08, 32'h00000100);
    expect_rd(8'h08, 32'h00000101, 32'hFFFFFFFF, "R12 load wins over step");

    // R7: zero-on-match bounds the counter
    wr(8'h00, 32'h0);
    wr(8'h20, 32'h00000008);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h00001200);
    for (int n = 0; n < 30; n++) begin
      @(posedge clk); #2; reg_addr = 8'h08;
      @(negedge clk);
      chk("R7 counter never passes threshold 0", {31'h0, (reg_rdata <= 32'd8)}, 32'h1);
    end
    wr(8'h00, 32'h0);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h00002200);
    repeat (20) @(posedge clk);
    expect_rd(8'h08, 32'h0, 32'hFFFFFFFF, "R7 counter back at zero");
    expect_rd(8'h00, 32'h0, 32'h00002000, "R7 stop bit cleared by match");

    // R11: unmapped offsets
    wr(8'h04, 32'hFFFFFFFF);
    wr(8'h30, 32'hFFFFFFFF);
    wr(8'hFC, 32'hFFFFFFFF);
    expect_rd(8'h04, 32'h0, 32'hFFFFFFFF, "R11 read of 0x04");
    expect_rd(8'hFC, 32'h0, 32'hFFFFFFFF, "R11 read of 0xFC");
    expect_rd(8'h20, 32'h00000008, 32'hFFFFFFFF, "R11 threshold untouched");
    expect_rd(8'h00, 32'h00000200, 32'h0FFFFFFF, "R11 config untouched");
    expect_rd(8'h08, 32'h0, 32'hFFFFFFFF, "R11 counter untouched");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule